// File: doc/BRIEF.md
# Two-Thread Branch Direction and Target Predictor

This block predicts branches for an in-order front end that runs two hardware threads. On every fetch it takes the thread number and the fetch address and answers, in the same cycle, whether the branch there is expected to be taken, where it goes, and whether that target is known. Direction comes from a table of 2-bit counters. The table is indexed by mixing address bits with a per-thread history of recent conditional outcomes, and both threads share it. Targets come from a set-associative target buffer. Function returns take their target from a per-thread return stack.

When a branch resolves, the execute stage reports it back. The report gives the thread, the address, the kind of branch, the outcome, the target and the instruction length. Counters and histories are trained on conditional branches only. The target buffer learns every taken branch. Calls push a return address and returns pop one. All training happens at resolve, so the state never holds wrong-path information. Recovering the fetch pipeline is left to the surrounding logic.

Top module: `bp_top`

## Requirements
- R1: After reset every counter holds weakly not-taken (01), the histories are zero, the target buffer is empty and both stacks are empty, so every lookup gives pr_taken=0 and pr_tgt_ok=0.
- R2: The direction counter for a lookup is at index lk_pc[13:2] XOR the 12-bit history of thread lk_tid. For a conditional entry or a buffer miss, pr_taken is that counter's upper bit.
- R3: pr_tgt_ok is 1 only when the address hits in the target buffer and the prediction is taken. A miss gives pr_tgt_ok=0 even when pr_taken=1.
- R4: A resolved conditional branch (rs_kind=0) moves its counter by one toward its outcome, saturating at 0 and 3. It also shifts its thread's history left with the outcome entering at bit 0. The counters are shared: one thread's training changes what the other thread reads.
- R5: Resolved jumps (rs_kind=1), calls (2) and returns (3) change neither the counters nor either history.
- R6: The target buffer has 32 sets of 4 ways, with the set taken from pc[6:2] and the tag from pc[31:7]. It is written by every taken conditional branch and by every jump, call and return. A hit on a jump or call predicts taken with the stored target.
- R7: On a miss, a write fills an empty way of the set if there is one. Otherwise it replaces the way of that set that was written least recently. A write to an entry already present makes that entry the most recent.
- R8: Each thread has its own 8-deep return stack. A call pushes rs_pc+rs_len and a return pops. A buffer hit of return kind predicts taken with the top of the looking-up thread's stack, and pr_tgt_ok is 1 only if that stack is not empty. A push onto a full stack overwrites the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_tid | input | 1 | Thread of the fetch lookup |
| lk_pc | input | 32 | Fetch address being predicted |
| pr_taken | output | 1 | Predicted direction |
| pr_target | output | 32 | Predicted target address |
| pr_tgt_ok | output | 1 | Target is known and usable |
| rs_valid | input | 1 | A resolved branch is reported this cycle |
| rs_tid | input | 1 | Thread of the resolved branch |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_kind | input | 2 | 0 conditional, 1 jump, 2 call, 3 return |
| rs_taken | input | 1 | Actual outcome |
| rs_target | input | 32 | Actual target |
| rs_len | input | 4 | Instruction length in bytes |

## Verification
The checks assume that at most one resolve arrives per cycle and that calls and returns come from the same thread's report, so a push and a pop never coincide on one stack. They also assume that jumps, calls and returns are reported with rs_taken high. The stimulus drives a single resolve per clock from one task, always marks unconditional kinds as taken, and keeps every input steady between clock edges. The address groups are chosen so that each test decides on purpose which target-buffer sets fill and which evict.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        BK_COND = 2'd0,
        BK_JUMP = 2'd1,
        BK_CALL = 2'd2,
        BK_RET  = 2'd3
    } br_kind_e;
endpackage

// File: rtl/bp_pht.sv
// Shared table of 2-bit saturating direction counters.
module bp_pht #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [1:0]       val;
    } pht_upd_t;

    logic [1:0] ctr_q [ENTRIES];
    pht_upd_t   upd_d;

    assign rd_ctr = ctr_q[rd_idx];

    always_comb begin
        logic [1:0] cur;
        cur       = ctr_q[wr_idx];
        upd_d.en  = wr_en;
        upd_d.idx = wr_idx;
        if (wr_taken) upd_d.val = (cur == 2'd3) ? cur : cur + 2'd1;
        else          upd_d.val = (cur == 2'd0) ? cur : cur - 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'b01;
        end else if (upd_d.en) begin
            ctr_q[upd_d.idx] <= upd_d.val;
        end
    end
endmodule

// File: rtl/bp_btb.sv
// Set-associative target buffer with per-set age-ordered replacement.
module bp_btb #(
    parameter int PC_W   = 32,
    parameter int SETS   = 32,
    parameter int WAYS   = 4,
    parameter int PC_LSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_target,
    output logic [1:0]      rd_kind,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_target,
    input  logic [1:0]      wr_kind
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = PC_W - PC_LSB - SET_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][PC_W-1:0]  tgt;
        logic [SETS-1:0][WAYS-1:0][1:0]       kind;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age;
    } btb_st_t;

    btb_st_t st_d, st_q;

    logic [SET_W-1:0] rd_set, wr_set;
    logic [TAG_W-1:0] rd_tag, wr_tag;

    assign rd_set = rd_pc[PC_LSB +: SET_W];
    assign rd_tag = rd_pc[PC_W-1 -: TAG_W];
    assign wr_set = wr_pc[PC_LSB +: SET_W];
    assign wr_tag = wr_pc[PC_W-1 -: TAG_W];

    always_comb begin
        rd_hit    = 1'b0;
        rd_target = '0;
        rd_kind   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (st_q.vld[rd_set][w] && st_q.tag[rd_set][w] == rd_tag) begin
                rd_hit    = 1'b1;
                rd_target = st_q.tgt[rd_set][w];
                rd_kind   = st_q.kind[rd_set][w];
            end
        end
    end

    always_comb begin
        logic             hit_any, inv_any;
        logic [WAY_W-1:0] hit_w, inv_w, old_w, sel, sel_age;
        st_d    = st_q;
        hit_any = 1'b0;
        inv_any = 1'b0;
        hit_w   = '0;
        inv_w   = '0;
        old_w   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!st_q.vld[wr_set][w]) begin
                inv_any = 1'b1;
                inv_w   = WAY_W'(w);
            end
            if (st_q.age[wr_set][w] == WAY_W'(WAYS - 1)) old_w = WAY_W'(w);
            if (st_q.vld[wr_set][w] && st_q.tag[wr_set][w] == wr_tag) begin
                hit_any = 1'b1;
                hit_w   = WAY_W'(w);
            end
        end
        sel     = hit_any ? hit_w : (inv_any ? inv_w : old_w);
        sel_age = st_q.age[wr_set][sel];
        if (wr_en) begin
            st_d.vld[wr_set][sel]  = 1'b1;
            st_d.tag[wr_set][sel]  = wr_tag;
            st_d.tgt[wr_set][sel]  = wr_target;
            st_d.kind[wr_set][sel] = wr_kind;
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == sel)
                    st_d.age[wr_set][w] = '0;
                else if (st_q.age[wr_set][w] < sel_age)
                    st_d.age[wr_set][w] = st_q.age[wr_set][w] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    st_q.age[s][w] <= WAY_W'(w);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bp_ras.sv
// Circular return-address stack; a push when full drops the oldest entry.
module bp_ras #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [PC_W-1:0]            push_val,
    input  logic                       pop,
    output logic [PC_W-1:0]            top_val,
    output logic                       top_ok,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] mem;
        logic [PTR_W-1:0]           ptr;
        logic [CNT_W-1:0]           cnt;
    } ras_st_t;

    ras_st_t st_d, st_q;

    assign top_val = st_q.mem[PTR_W'(st_q.ptr - 1'b1)];
    assign top_ok  = (st_q.cnt != '0);
    assign cnt     = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.ptr] = push_val;
            st_d.ptr           = st_q.ptr + 1'b1;
            if (st_q.cnt != CNT_W'(DEPTH)) st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && st_q.cnt != '0) begin
            st_d.ptr = st_q.ptr - 1'b1;
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bp_top.sv
module bp_top #(
    parameter  int PC_W      = 32,
    parameter  int THREADS   = 2,
    parameter  int GHR_W     = 12,
    parameter  int BTB_SETS  = 32,
    parameter  int BTB_WAYS  = 4,
    parameter  int RAS_DEPTH = 8,
    parameter  int PC_LSB    = 2,
    parameter  int LEN_W     = 4,
    localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int CNT_W     = $clog2(RAS_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TID_W-1:0] lk_tid,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             pr_taken,
    output logic [PC_W-1:0]  pr_target,
    output logic             pr_tgt_ok,
    input  logic             rs_valid,
    input  logic [TID_W-1:0] rs_tid,
    input  logic [PC_W-1:0]  rs_pc,
    input  logic [1:0]       rs_kind,
    input  logic             rs_taken,
    input  logic [PC_W-1:0]  rs_target,
    input  logic [LEN_W-1:0] rs_len
);
    import bp_pkg::*;

    typedef struct packed {
        logic [THREADS-1:0][GHR_W-1:0] ghr;
    } bpu_st_t;

    bpu_st_t st_d, st_q;

    logic [THREADS-1:0][GHR_W-1:0] ghr_q;
    logic [GHR_W-1:0]              rd_idx, wr_idx;
    logic [1:0]                    pht_ctr;
    logic                          is_cond, btb_hit;
    logic [PC_W-1:0]               btb_tgt;
    logic [1:0]                    btb_kind;
    logic [THREADS-1:0][PC_W-1:0]  ras_top;
    logic [THREADS-1:0]            ras_ok;
    logic [THREADS-1:0][CNT_W-1:0] ras_cnt;

    assign ghr_q   = st_q.ghr;
    assign is_cond = (rs_kind == BK_COND);
    assign rd_idx  = lk_pc[PC_LSB +: GHR_W] ^ st_q.ghr[lk_tid];
    assign wr_idx  = rs_pc[PC_LSB +: GHR_W] ^ st_q.ghr[rs_tid];

    bp_pht #(.IDX_W(GHR_W)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_ctr   (pht_ctr),
        .wr_en    (rs_valid && is_cond),
        .wr_idx   (wr_idx),
        .wr_taken (rs_taken)
    );

    bp_btb #(.PC_W(PC_W), .SETS(BTB_SETS), .WAYS(BTB_WAYS), .PC_LSB(PC_LSB)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (lk_pc),
        .rd_hit    (btb_hit),
        .rd_target (btb_tgt),
        .rd_kind   (btb_kind),
        .wr_en     (rs_valid && (rs_taken || !is_cond)),
        .wr_pc     (rs_pc),
        .wr_target (rs_target),
        .wr_kind   (rs_kind)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_ras
        logic mine;
        assign mine = rs_valid && (rs_tid == TID_W'(t));
        bp_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (mine && rs_kind == BK_CALL),
            .push_val (rs_pc + {{(PC_W-LEN_W){1'b0}}, rs_len}),
            .pop      (mine && rs_kind == BK_RET),
            .top_val  (ras_top[t]),
            .top_ok   (ras_ok[t]),
            .cnt      (ras_cnt[t])
        );
    end

    always_comb begin
        pr_taken  = pht_ctr[1];
        pr_target = btb_tgt;
        pr_tgt_ok = 1'b0;
        if (btb_hit) begin
            case (br_kind_e'(btb_kind))
                BK_COND: pr_tgt_ok = pht_ctr[1];
                BK_JUMP,
                BK_CALL: begin
                    pr_taken  = 1'b1;
                    pr_tgt_ok = 1'b1;
                end
                default: begin
                    pr_taken  = 1'b1;
                    pr_target = ras_top[lk_tid];
                    pr_tgt_ok = ras_ok[lk_tid];
                end
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        if (rs_valid && is_cond)
            st_d.ghr[rs_tid] = {st_q.ghr[rs_tid][GHR_W-2:0], rs_taken};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter int THREADS   = 2,
    parameter int GHR_W     = 12,
    parameter int CNT_W     = 4,
    parameter int TID_W     = 1,
    parameter int RAS_DEPTH = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          pr_taken,
    input logic                          pr_tgt_ok,
    input logic                          rs_valid,
    input logic [TID_W-1:0]              rs_tid,
    input logic [1:0]                    rs_kind,
    input logic                          rs_taken,
    input logic [THREADS-1:0][GHR_W-1:0] ghr_q,
    input logic [THREADS-1:0][CNT_W-1:0] ras_cnt
);
    a_r3_target_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
        pr_tgt_ok |-> pr_taken);

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        a_r4_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
            (rs_valid && rs_kind == 2'd0 && rs_tid == TID_W'(t)) |=>
            ghr_q[t] == {$past(ghr_q[t][GHR_W-2:0]), $past(rs_taken)});

        a_r5_history_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(rs_valid && rs_kind == 2'd0 && rs_tid == TID_W'(t)) |=> $stable(ghr_q[t]));

        a_r8_stack_bound: assert property (@(posedge clk) disable iff (!rst_n)
            ras_cnt[t] <= CNT_W'(RAS_DEPTH));

        a_r8_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
            (rs_valid && rs_kind == 2'd2 && rs_tid == TID_W'(t) && ras_cnt[t] < CNT_W'(RAS_DEPTH))
            |=> ras_cnt[t] == $past(ras_cnt[t]) + 1'b1);

        a_r8_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
            (rs_valid && rs_kind == 2'd3 && rs_tid == TID_W'(t) && ras_cnt[t] != '0)
            |=> ras_cnt[t] == $past(ras_cnt[t]) - 1'b1);
    end
endmodule

bind bp_top bp_checker #(
    .THREADS(THREADS), .GHR_W(GHR_W), .CNT_W(CNT_W), .TID_W(TID_W), .RAS_DEPTH(RAS_DEPTH)
) u_chk (.*);

// File: tb/sim_bp_top.sv
module sim_bp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  lk_tid = '0;
    logic [31:0] lk_pc = '0;
    logic        pr_taken, pr_tgt_ok;
    logic [31:0] pr_target;
    logic        rs_valid = 1'b0;
    logic [0:0]  rs_tid = '0;
    logic [31:0] rs_pc = '0;
    logic [1:0]  rs_kind = '0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = '0;
    logic [3:0]  rs_len = '0;

    always #5 clk = ~clk;

    bp_top u0 (.*);

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [1:0]  m_ctr [4096];
    logic [11:0] m_hist [2];
    bit          m_seen [8];
    logic [31:0] stk_val [10];

    function automatic logic [11:0] m_idx(input int tid, input logic [31:0] pc);
        return pc[13:2] ^ m_hist[tid];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic look(input int tid, input logic [31:0] pc);
        lk_tid = tid[0:0];
        lk_pc  = pc;
        #1;
    endtask

    task automatic resolve(input int tid, input logic [31:0] pc, input logic [1:0] kind,
                           input logic taken, input logic [31:0] tgt, input logic [3:0] len);
        logic [11:0] ix;
        @(negedge clk);
        rs_valid = 1'b1; rs_tid = tid[0:0]; rs_pc = pc; rs_kind = kind;
        rs_taken = taken; rs_target = tgt; rs_len = len;
        if (kind == 2'd0) begin
            ix = m_idx(tid, pc);
            if (taken && m_ctr[ix] != 2'd3) m_ctr[ix] = m_ctr[ix] + 2'd1;
            if (!taken && m_ctr[ix] != 2'd0) m_ctr[ix] = m_ctr[ix] - 2'd1;
            m_hist[tid] = {m_hist[tid][10:0], taken};
        end
        @(posedge clk);
        #1;
        rs_valid = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] pc, p_j, q_j, r_pc;
        logic [31:0] lp [5];
        for (int i = 0; i < 4096; i++) m_ctr[i] = 2'b01;
        m_hist[0] = '0; m_hist[1] = '0;
        for (int k = 0; k < 8; k++) m_seen[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 64; i++) begin
            for (int t = 0; t < 2; t++) begin
                look(t, 32'h100 + i * 36);
                check("R1", "taken after reset", pr_taken, 0);
                check("R1", "tgt_ok after reset", pr_tgt_ok, 0);
            end
        end

        // R2 R3 R4: conditional training on both threads, shared counters
        for (int it = 0; it < 240; it++) begin
            int k, t;
            logic tk, e_tk;
            k  = it % 8;
            t  = (it / 8) % 2;
            pc = 32'h1000 + k * 32'h24;
            tk = (it % (k + 2)) != 0;
            look(t, pc);
            e_tk = m_ctr[m_idx(t, pc)][1];
            check("R2", "gshare direction", pr_taken, e_tk);
            check("R3", "tgt_ok on conditional", pr_tgt_ok, e_tk && m_seen[k]);
            if (e_tk && m_seen[k]) check("R6", "conditional target", pr_target, 32'h7000 + k * 4);
            resolve(t, pc, 2'd0, tk, 32'h7000 + k * 4, 4'd4);
            if (tk) m_seen[k] = 1;
        end

        // R5 R6: jumps leave counters and histories alone
        p_j = 32'h0005_0040;
        q_j = p_j ^ 32'h0010_0000;
        for (int i = 0; i < 4; i++) resolve(i % 2, p_j, 2'd1, 1'b1, 32'h0006_0000, 4'd2);
        for (int t = 0; t < 2; t++) begin
            look(t, q_j);
            check("R5", "alias after jumps", pr_taken, m_ctr[m_idx(t, q_j)][1]);
            check("R3", "miss has no target", pr_tgt_ok, 0);
            look(t, p_j);
            check("R6", "jump taken", pr_taken, 1);
            check("R6", "jump tgt_ok", pr_tgt_ok, 1);
            check("R6", "jump target", pr_target, 32'h0006_0000);
        end
        for (int k = 0; k < 8; k++) begin
            pc = 32'h1000 + k * 32'h24;
            look(1, pc);
            check("R5", "history intact after jumps", pr_taken, m_ctr[m_idx(1, pc)][1]);
        end

        // R7: replacement in set 7
        for (int i = 0; i < 5; i++) lp[i] = ((i + 1) << 16) | 32'h1C;
        for (int i = 0; i < 4; i++) resolve(0, lp[i], 2'd1, 1'b1, 32'hA000 + i * 16, 4'd2);
        for (int i = 0; i < 4; i++) begin
            look(0, lp[i]);
            check("R7", "fill empty ways", pr_tgt_ok, 1);
            check("R7", "fill target", pr_target, 32'hA000 + i * 16);
        end
        resolve(0, lp[4], 2'd1, 1'b1, 32'hA040, 4'd2);
        look(0, lp[0]);
        check("R7", "oldest evicted", pr_tgt_ok, 0);
        check("R7", "evicted falls back to counter", pr_taken, m_ctr[m_idx(0, lp[0])][1]);
        for (int i = 1; i < 5; i++) begin
            look(0, lp[i]);
            check("R7", "survivors hit", pr_tgt_ok, 1);
        end
        resolve(0, lp[1], 2'd1, 1'b1, 32'hA014, 4'd2);
        resolve(0, lp[0], 2'd1, 1'b1, 32'hA000, 4'd2);
        look(0, lp[2]);
        check("R7", "next oldest evicted after touch", pr_tgt_ok, 0);
        look(0, lp[1]);
        check("R7", "touched entry kept", pr_tgt_ok, 1);
        check("R7", "touched entry new target", pr_target, 32'hA014);
        look(0, lp[0]);
        check("R7", "reinserted entry", pr_tgt_ok, 1);

        // R8: per-thread return stacks
        r_pc = 32'h9004;
        resolve(0, 32'h8000, 2'd2, 1'b1, 32'h3000, 4'd4);
        resolve(0, r_pc, 2'd3, 1'b1, 32'h8004, 4'd1);
        for (int t = 0; t < 2; t++) begin
            look(t, r_pc);
            check("R8", "return predicted taken", pr_taken, 1);
            check("R8", "empty stack no target", pr_tgt_ok, 0);
        end
        for (int i = 0; i < 10; i++) begin
            pc = 32'h8000 + i * 32'h80;
            stk_val[i] = pc + (i % 8) + 2;
            resolve(0, pc, 2'd2, 1'b1, 32'h3000, 4'((i % 8) + 2));
        end
        look(1, r_pc);
        check("R8", "other thread stack empty", pr_tgt_ok, 0);
        for (int j = 0; j < 8; j++) begin
            look(0, r_pc);
            check("R8", "stack top valid", pr_tgt_ok, 1);
            check("R8", "stack top value", pr_target, stk_val[9 - j]);
            resolve(0, r_pc, 2'd3, 1'b1, stk_val[9 - j], 4'd1);
        end
        look(0, r_pc);
        check("R8", "overflow dropped oldest", pr_tgt_ok, 0);
        resolve(1, 32'h8800, 2'd2, 1'b1, 32'h3000, 4'd6);
        look(1, r_pc);
        check("R8", "thread 1 push visible", pr_tgt_ok, 1);
        check("R8", "thread 1 top", pr_target, 32'h8806);
        look(0, r_pc);
        check("R8", "thread 0 unaffected", pr_tgt_ok, 0);
        for (int k = 0; k < 8; k++) begin
            pc = 32'h1000 + k * 32'h24 + 32'h0100_0000;
            look(k % 2, pc);
            check("R5", "calls and returns keep history", pr_taken, m_ctr[m_idx(k % 2, pc)][1]);
        end

        finish_run();
    end
endmodule